// File: doc/BRIEF.md
# Single-Vector Interrupt Acceptance Sequencer

This block decides, at every instruction boundary of a small 8-bit CPU, whether to take a maskable interrupt from one level-sensitive, active-low request line. It sits between the fetch stage and the decoder. When it takes the interrupt, it stalls the program counter and the opcode read. In their place it offers the decoder a one-byte restart opcode (0xFF). The decoder runs that opcode as a call: it pushes the current program counter and jumps to the fixed handler entry at 0x0038.

The block owns the interrupt-enable flag. The enable-instruction and disable-instruction strobes from the execute stage drive it. After an enable, the block ignores a pending request for a short window of boundaries. A handler that ends with enable followed by return therefore gets back to the interrupted code before it can be entered again. The request has no memory inside the block: only its level at the decision point counts.

The substituted opcode leaves on a valid/ready stream. `inject_valid` rises in the cycle after the accepting boundary, and the opcode stays stable while `inject_ready` is low. The transfer completes in a cycle where both are high. `hold_pc` and `suppress_fetch` stay high for as long as the offer is open. Boundaries seen while an offer is open are ignored.

Top module: `irq_accept_seq`

## Requirements
- R1: `irq_n` passes through a two-flop synchronizer that resets to the released level. A decision made at a rising edge uses the `irq_n` level captured two rising edges earlier.
- R2: An acceptance happens at a rising edge only when all of the following hold in that cycle: `instr_boundary` is high, the synchronized request is low (asserted), `ie_flag` is 1, the enable shadow is empty, neither `ei_exec` nor `di_exec` is high, and no offer is open.
- R3: From the cycle after an acceptance, `inject_valid`, `hold_pc` and `suppress_fetch` are 1 and `inject_opcode` is 0xFF. They stay so up to and including the first cycle with `inject_ready` high, and are all 0 from the next cycle on. Outside an offer, `inject_opcode` is 0x00.
- R4: `ie_flag` becomes 0 at the same edge where an acceptance happens.
- R5: `ie_flag` resets to 0. A cycle with `di_exec` makes it 0 at the next edge. A cycle with `ei_exec` and no `di_exec` makes it 1. When both strobes are high, `di_exec` wins and `ei_exec` is ignored.
- R6: An `ei_exec` (without `di_exec`) blocks the boundary in its own cycle and the next SHADOW_LEN (default 2) boundaries when it does not coincide with a boundary. When it does coincide, it blocks that boundary and the next SHADOW_LEN-1 boundaries. Each further `ei_exec` restarts the window, so consecutive enables defer acceptance past the last one.
- R7: The request is level-sensitive. A low pulse on `irq_n` that is gone before an eligible decision causes no acceptance. A request still held low is taken at the first eligible boundary, such as the end of the first instruction after an enable-then-return pair.
- R8: While an offer is open, `inject_opcode` stays stable, and `instr_boundary` pulses neither start a new acceptance nor advance the enable shadow.
- R9: During and right after reset, `inject_valid`, `hold_pc`, `suppress_fetch` and `ie_flag` are 0 and `inject_opcode` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Active-low, level-sensitive interrupt request (asynchronous) |
| instr_boundary | input | 1 | High in the last cycle of each instruction (decision point) |
| ei_exec | input | 1 | Enable-interrupts instruction strobe |
| di_exec | input | 1 | Disable-interrupts instruction strobe |
| inject_ready | input | 1 | Decoder accepts the offered opcode |
| inject_opcode | output | 8 | Substituted restart opcode (0xFF while offered, else 0x00) |
| inject_valid | output | 1 | Restart opcode is on offer |
| hold_pc | output | 1 | Freeze the program-counter increment |
| suppress_fetch | output | 1 | Skip the memory read for the next opcode |
| ie_flag | output | 1 | Interrupt-enable flag |

## Verification
The bench aims at the enable shadow in three forms: an enable standing alone, an enable that lands on a boundary, and back-to-back enables. A design with the window one boundary short would re-enter the handler before its return. One with the window too long would let one more user instruction run before the handler.

A request arriving one cycle too late for the synchronizer must be missed, and one arriving exactly in time must be taken. This exposes a synchronizer that is missing or a stage too deep. A short low glitch must leave no latched request behind.

Stalled handshakes with boundaries arriving during the stall, and a disable that coincides with an enable, round out the directed part. A random phase then compares every output on every cycle against a behavioural model.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned OPCODE_W        = 8;
  localparam logic [OPCODE_W-1:0] RESTART_OPCODE = 8'hFF;
  localparam logic [OPCODE_W-1:0] IDLE_OPCODE    = 8'h00;
  localparam int unsigned SYNC_STAGES     = 2;
  localparam int unsigned SHADOW_BOUNDARIES = 2;

  typedef enum logic [0:0] {
    OFFER_IDLE = 1'b0,
    OFFER_OPEN = 1'b1
  } offer_state_e;
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RESET_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ie_shadow_ctrl.sv
module ie_shadow_ctrl #(
  parameter int unsigned SHADOW_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ei_exec,
  input  logic di_exec,
  input  logic boundary_live,
  input  logic accept,
  output logic ie_flag,
  output logic shadow_busy
);
  localparam int unsigned CW = $clog2(SHADOW_LEN + 1);
  localparam logic [CW-1:0] LOAD_FULL = CW'(SHADOW_LEN);
  localparam logic [CW-1:0] LOAD_SAME = CW'(SHADOW_LEN - 1);

  logic [CW-1:0] shadow_q;
  logic          ie_q;
  logic          enable_req;

  assign enable_req = ei_exec && !di_exec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (di_exec) begin
      ie_q <= 1'b0;
    end else if (ei_exec) begin
      ie_q <= 1'b1;
    end else if (accept) begin
      ie_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (enable_req) begin
      shadow_q <= boundary_live ? LOAD_SAME : LOAD_FULL;
    end else if (boundary_live && (shadow_q != '0)) begin
      shadow_q <= shadow_q - CW'(1);
    end
  end

  assign ie_flag     = ie_q;
  assign shadow_busy = (shadow_q != '0);
endmodule

// File: rtl/restart_inject.sv
module restart_inject
  import irq_seq_pkg::*;
#(
  parameter logic [OPCODE_W-1:0] OPCODE = RESTART_OPCODE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                inject_ready,
  output logic                offer_open,
  output logic [OPCODE_W-1:0] inject_opcode,
  output logic                hold_pc,
  output logic                suppress_fetch
);
  offer_state_e state_q, state_d;
  logic [OPCODE_W-1:0] opcode_q;
  logic                hold_q;
  logic                supp_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OFFER_IDLE: if (accept)       state_d = OFFER_OPEN;
      OFFER_OPEN: if (inject_ready) state_d = OFFER_IDLE;
      default:                      state_d = OFFER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= OFFER_IDLE;
      opcode_q <= IDLE_OPCODE;
      hold_q   <= 1'b0;
      supp_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      opcode_q <= (state_d == OFFER_OPEN) ? OPCODE : IDLE_OPCODE;
      hold_q   <= (state_d == OFFER_OPEN);
      supp_q   <= (state_d == OFFER_OPEN);
    end
  end

  assign offer_open     = (state_q == OFFER_OPEN);
  assign inject_opcode  = opcode_q;
  assign hold_pc        = hold_q;
  assign suppress_fetch = supp_q;
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned STAGES     = SYNC_STAGES,
  parameter int unsigned SHADOW_LEN = SHADOW_BOUNDARIES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_n,
  input  logic                instr_boundary,
  input  logic                ei_exec,
  input  logic                di_exec,
  input  logic                inject_ready,
  output logic [OPCODE_W-1:0] inject_opcode,
  output logic                inject_valid,
  output logic                hold_pc,
  output logic                suppress_fetch,
  output logic                ie_flag
);
  logic irq_n_sync;
  logic offer_open;
  logic boundary_live;
  logic shadow_busy;
  logic ie_now;
  logic gate_open;
  logic accept;

  irq_level_sync #(.STAGES(STAGES), .RESET_VAL(1'b1)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_n),
    .sync_out (irq_n_sync)
  );

  assign boundary_live = instr_boundary && !offer_open;
  assign gate_open     = ie_now && !shadow_busy && !ei_exec && !di_exec;
  assign accept        = boundary_live && !irq_n_sync && gate_open;

  ie_shadow_ctrl #(.SHADOW_LEN(SHADOW_LEN)) ie_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ei_exec       (ei_exec),
    .di_exec       (di_exec),
    .boundary_live (boundary_live),
    .accept        (accept),
    .ie_flag       (ie_now),
    .shadow_busy   (shadow_busy)
  );

  restart_inject #(.OPCODE(RESTART_OPCODE)) inj_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .inject_ready   (inject_ready),
    .offer_open     (offer_open),
    .inject_opcode  (inject_opcode),
    .hold_pc        (hold_pc),
    .suppress_fetch (suppress_fetch)
  );

  assign inject_valid = offer_open;
  assign ie_flag      = ie_now;
endmodule

// File: rtl/irq_accept_seq_chk.sv
module irq_accept_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_boundary,
  input logic       ei_exec,
  input logic       di_exec,
  input logic       inject_ready,
  input logic [7:0] inject_opcode,
  input logic       inject_valid,
  input logic       ie_flag
);
  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (inject_valid && !inject_ready) |=> (inject_valid && $stable(inject_opcode))); // R8
  AST_OFFER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (inject_valid && inject_ready) |=> !inject_valid); // R3
  AST_OPCODE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    inject_valid |-> (inject_opcode == 8'hFF)); // R3
  AST_ACCEPT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inject_valid) |-> $past(instr_boundary)); // R2
  AST_ACCEPT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inject_valid) |-> $past(ie_flag)); // R2
  AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inject_valid) |-> !ie_flag); // R4
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    di_exec |=> !ie_flag); // R5
  AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_exec && !di_exec) |=> ie_flag); // R5
  AST_SHADOW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_exec && !inject_valid) |=> !inject_valid); // R6
endmodule

bind irq_accept_seq irq_accept_seq_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .instr_boundary (instr_boundary),
  .ei_exec        (ei_exec),
  .di_exec        (di_exec),
  .inject_ready   (inject_ready),
  .inject_opcode  (inject_opcode),
  .inject_valid   (inject_valid),
  .ie_flag        (ie_flag)
);

// File: tb/irq_accept_seq_tb_top.sv
`timescale 1ns/1ps
module irq_accept_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_n = 1'b1;
  logic instr_boundary = 1'b0;
  logic ei_exec = 1'b0;
  logic di_exec = 1'b0;
  logic inject_ready = 1'b1;
  logic [7:0] inject_opcode;
  logic inject_valid, hold_pc, suppress_fetch, ie_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_accept_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .instr_boundary(instr_boundary),
    .ei_exec(ei_exec), .di_exec(di_exec), .inject_ready(inject_ready),
    .inject_opcode(inject_opcode), .inject_valid(inject_valid), .hold_pc(hold_pc),
    .suppress_fetch(suppress_fetch), .ie_flag(ie_flag)
  );

  // Behavioural reference model
  bit m_ie = 0, m_pend = 0;
  int m_shadow = 0;
  bit irq_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ie = 0; m_pend = 0; m_shadow = 0;
      irq_hist = '{1'b1, 1'b1};
    end else begin
      bit live, acc, req;
      req  = (irq_hist[1] == 1'b0);
      live = instr_boundary && !m_pend;
      acc  = live && req && m_ie && (m_shadow == 0) && !ei_exec && !di_exec;
      if (m_pend) m_pend = !inject_ready; else m_pend = acc;
      if (di_exec) m_ie = 0; else if (ei_exec) m_ie = 1; else if (acc) m_ie = 0;
      if (ei_exec && !di_exec) m_shadow = live ? 1 : 2;
      else if (live && m_shadow > 0) m_shadow--;
      irq_hist.push_front(irq_n);
      void'(irq_hist.pop_back());
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(inject_valid == m_pend, "R3", "inject_valid", inject_valid, m_pend);
      chk(inject_opcode == (m_pend ? 8'hFF : 8'h00), "R3", "inject_opcode",
          inject_opcode, m_pend ? 8'hFF : 8'h00);
      chk(hold_pc == m_pend, "R3", "hold_pc", hold_pc, m_pend);
      chk(suppress_fetch == m_pend, "R3", "suppress_fetch", suppress_fetch, m_pend);
      chk(ie_flag == m_ie, "R5", "ie_flag", ie_flag, m_ie);
    end
  end

  task automatic cyc(bit b, bit e, bit d, bit r);
    instr_boundary = b; ei_exec = e; di_exec = d; inject_ready = r;
    @(negedge clk);
    instr_boundary = 0; ei_exec = 0; di_exec = 0; inject_ready = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(inject_valid == 0 && hold_pc == 0 && suppress_fetch == 0, "R9", "stall outs", inject_valid, 0);
    chk(ie_flag == 0 && inject_opcode == 8'h00, "R9", "ie/opcode", ie_flag, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 masked request is not accepted
    irq_n = 0;
    repeat (3) cyc(0, 0, 0, 1);
    cyc(1, 0, 0, 1); cyc(1, 0, 0, 1);
    chk(inject_valid == 0, "R2", "masked accept", inject_valid, 0);

    // R6 lone enable blocks two boundaries, then accept with back-pressure
    cyc(0, 1, 0, 1);
    chk(ie_flag == 1, "R5", "ei sets", ie_flag, 1);
    cyc(1, 0, 0, 1); chk(inject_valid == 0, "R6", "shadow b1", inject_valid, 0);
    cyc(1, 0, 0, 1); chk(inject_valid == 0, "R6", "shadow b2", inject_valid, 0);
    cyc(1, 0, 0, 0); chk(inject_valid == 1, "R2", "accept", inject_valid, 1);
    chk(ie_flag == 0, "R4", "ie cleared on accept", ie_flag, 0);
    chk(inject_opcode == 8'hFF && hold_pc && suppress_fetch, "R3", "offer outs", inject_opcode, 8'hFF);
    cyc(1, 0, 0, 0); chk(inject_valid == 1 && inject_opcode == 8'hFF, "R8", "held under stall", inject_valid, 1);
    cyc(0, 0, 0, 1); chk(inject_valid == 0 && hold_pc == 0, "R3", "offer closes", inject_valid, 0);

    // R7 enable-then-return, request still low: taken after first user instruction
    cyc(1, 1, 0, 1);   // EI on its own boundary
    cyc(1, 0, 0, 1);   // RET boundary
    chk(inject_valid == 0, "R6", "no reentry at return", inject_valid, 0);
    cyc(1, 0, 0, 1);
    chk(inject_valid == 1, "R7", "reaccept after first instr", inject_valid, 1);
    cyc(0, 0, 0, 1);

    // R6 consecutive enables
    cyc(1, 1, 0, 1); cyc(1, 1, 0, 1); cyc(1, 0, 0, 1);
    chk(inject_valid == 0, "R6", "consecutive ei deferral", inject_valid, 0);
    cyc(1, 0, 0, 1);
    chk(inject_valid == 1, "R6", "accept after last ei", inject_valid, 1);
    cyc(0, 0, 0, 1);

    // R5 disable and disable-wins
    cyc(0, 1, 0, 1); cyc(0, 0, 1, 1);
    chk(ie_flag == 0, "R5", "di clears", ie_flag, 0);
    repeat (3) cyc(1, 0, 0, 1);
    chk(inject_valid == 0, "R5", "no accept after di", inject_valid, 0);
    cyc(0, 1, 1, 1);
    chk(ie_flag == 0, "R5", "di wins over ei", ie_flag, 0);

    // R1 synchronizer latency
    irq_n = 1;
    cyc(0, 1, 0, 1); repeat (3) cyc(1, 0, 0, 1);
    irq_n = 0;
    cyc(1, 0, 0, 1); chk(inject_valid == 0, "R1", "edge A", inject_valid, 0);
    cyc(1, 0, 0, 1); chk(inject_valid == 0, "R1", "edge B too early", inject_valid, 0);
    cyc(1, 0, 0, 1); chk(inject_valid == 1, "R1", "edge C seen", inject_valid, 1);
    cyc(0, 0, 0, 1);

    // R7 short glitch leaves nothing behind
    irq_n = 1;
    cyc(0, 1, 0, 1); repeat (3) cyc(1, 0, 0, 1);
    irq_n = 0; cyc(0, 0, 0, 1); irq_n = 1;
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    repeat (3) cyc(1, 0, 0, 1);
    chk(inject_valid == 0 && ie_flag == 1, "R7", "glitch ignored", inject_valid, 0);

    // Random phase against the model
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 8) == 0) irq_n = ~irq_n;
      cyc(($urandom % 3) == 0, ($urandom % 9) == 0, ($urandom % 13) == 0, ($urandom % 3) != 0);
    end

    finish_run();
  end
endmodule